// File: doc/BRIEF.md
# CAN Overload Condition Detector

This block sits beside the bit-level state machine of a CAN protocol engine and decides when an overload frame has to be started. At each sample point the engine presents the sampled bus level, a code for the field the bit belongs to, the index of the bit within that field, and whether the current frame is being received or transmitted. The detector watches for a dominant level at the specific bit positions where the protocol treats dominant as an overload condition.

When such a condition is found, the block raises a registered request for one clock cycle. At the same time it presents a two-bit code that gives the cause. The engine uses the request to switch into sending an overload flag. Bit timing, destuffing, CRC and the generation of the flag waveform are all handled elsewhere.

Top module: `ovld_detect`

## Requirements
- R1: A dominant level (bus_rx = 0) sampled in intermission (field_sel = 2) at bit index 0 or 1 raises ovl_req with ovl_cause = 0.
- R2: A dominant level in intermission at bit index 2 (third bit, a start of frame) raises no request.
- R3: A dominant level at end-of-frame (field_sel = 1) bit index 6 while receiving (rx_mode = 1) raises ovl_req with ovl_cause = 1. End-of-frame bits 0 to 5 never raise a request.
- R4: A dominant level at end-of-frame bit index 6 while transmitting (rx_mode = 0) raises no request.
- R5: A dominant level at error delimiter (field_sel = 3) bit index 7 raises ovl_req with ovl_cause = 2. Earlier delimiter bits raise nothing.
- R6: A dominant level at overload delimiter (field_sel = 4) bit index 7 raises ovl_req with ovl_cause = 3. Earlier delimiter bits raise nothing.
- R7: A recessive sample never raises a request. Field code 0 (other) and the unused codes 5 to 7 never raise a request, at any bit index.
- R8: Inputs are evaluated only when sample_en is 1. With sample_en at 0 no request is raised.
- R9: ovl_req goes high in the clock cycle that follows the edge at which the qualifying sample was taken. It stays high for exactly that one cycle unless the next edge also carries a qualifying sample. While ovl_req is 0, ovl_cause reads 0.
- R10: Reset is synchronous and active low. It clears ovl_req and ovl_cause to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sample_en | input | 1 | Sample-point strobe from the bit timing logic |
| bus_rx | input | 1 | Sampled bus level, 0 dominant, 1 recessive |
| field_sel | input | 3 | Field code: 0 other, 1 end-of-frame, 2 intermission, 3 error delimiter, 4 overload delimiter |
| bit_idx | input | 4 | Zero-based bit position within the current field |
| rx_mode | input | 1 | 1 while receiving the frame, 0 while transmitting |
| ovl_req | output | 1 | One-cycle request to start an overload frame |
| ovl_cause | output | 2 | Cause: 0 intermission, 1 end-of-frame, 2 error delimiter, 3 overload delimiter |

## Verification
Every trigger position is driven with a dominant sample and with its immediate neighbours: intermission bits 0, 1 and 2, end-of-frame bits 5 and 6, and delimiter bits 6 and 7. These cases show that the position decoding stops exactly at the protocol boundary. The final end-of-frame bit is driven once while receiving and once while transmitting, which separates the two directions. Recessive samples, the "other" and unused field codes, and trigger positions presented without the strobe each show that a request needs all of the qualifying conditions together. Directed sequences then check the one-cycle pulse width, back-to-back requests with different causes, and a reset that arrives while a request is pending.

// File: rtl/ovld_pkg.sv
// Package: shared encodings for the overload condition detector.
// Assumes field codes come from the protocol engine's bit state machine.
package ovld_pkg;

    // Field codes presented by the protocol engine with each sampled bit.
    typedef enum logic [2:0] {
        FLD_OTHER  = 3'd0,
        FLD_EOF    = 3'd1,
        FLD_IFS    = 3'd2,
        FLD_ERRDLM = 3'd3,
        FLD_OVLDLM = 3'd4
    } field_e;

    // Cause codes reported alongside an overload request.
    typedef enum logic [1:0] {
        CAUSE_IFS    = 2'd0,
        CAUSE_EOF    = 2'd1,
        CAUSE_ERRDLM = 2'd2,
        CAUSE_OVLDLM = 2'd3
    } cause_e;

    localparam int unsigned NUM_CAUSES = 4;

    // Hit-vector bit positions; the bit index equals the cause code.
    localparam int unsigned HIT_IFS    = 0;
    localparam int unsigned HIT_EOF    = 1;
    localparam int unsigned HIT_ERRDLM = 2;
    localparam int unsigned HIT_OVLDLM = 3;

endpackage

// File: rtl/ovld_field_decode.sv
// Module: ovld_field_decode
// Compares the field code and bit index against the protocol positions
// at which a dominant bit means overload. It produces one hit flag per
// cause. Purely combinational. Assumes the strobe and the bus level are
// qualified by the caller.
module ovld_field_decode
    import ovld_pkg::*;
#(
    parameter int unsigned IDX_W     = 4,
    parameter int unsigned IFS_BITS  = 2,  // leading intermission bits that trigger
    parameter int unsigned EOF_LEN   = 7,
    parameter int unsigned DLM_LEN   = 8
) (
    input  logic [2:0]            field_sel,
    input  logic [IDX_W-1:0]      bit_idx,
    input  logic                  rx_mode,
    output logic [NUM_CAUSES-1:0] hit
);
    localparam logic [IDX_W-1:0] EOF_LAST = IDX_W'(EOF_LEN - 1);
    localparam logic [IDX_W-1:0] DLM_LAST = IDX_W'(DLM_LEN - 1);

    logic [IFS_BITS-1:0] ifs_pos;

    // One comparator per triggering intermission position.
    for (genvar g = 0; g < IFS_BITS; g++) begin : g_ifs_pos
        assign ifs_pos[g] = (bit_idx == IDX_W'(g));
    end

    // Map field and position onto the per-cause hit flags.
    always_comb begin
        hit             = '0;
        hit[HIT_IFS]    = (field_sel == FLD_IFS)    && (|ifs_pos);
        hit[HIT_EOF]    = (field_sel == FLD_EOF)    && (bit_idx == EOF_LAST) && rx_mode;
        hit[HIT_ERRDLM] = (field_sel == FLD_ERRDLM) && (bit_idx == DLM_LAST);
        hit[HIT_OVLDLM] = (field_sel == FLD_OVLDLM) && (bit_idx == DLM_LAST);
    end

endmodule

// File: rtl/ovld_cause_enc.sv
// Module: ovld_cause_enc
// Turns the per-cause hit flags into a valid flag and a cause code.
// The lowest-numbered hit wins. Assumes the hits normally arrive one-hot,
// because only one field is active at a time.
module ovld_cause_enc
    import ovld_pkg::*;
(
    input  logic [NUM_CAUSES-1:0] hit,
    output logic                  any_hit,
    output logic [1:0]            cause
);
    // Priority-encode the hit vector, scanning from the top down.
    always_comb begin
        cause = '0;
        for (int i = NUM_CAUSES - 1; i >= 0; i--) begin
            if (hit[i]) cause = 2'(i);
        end
        any_hit = |hit;
    end

endmodule

// File: rtl/ovld_detect.sv
// Module: ovld_detect (top)
// Overload condition detector. On each sample-point strobe that carries a
// dominant bus level, it checks the field and bit position. If an overload
// condition is found, it registers a one-cycle request and a cause code.
// Assumes synchronous active-low reset and one strobe per sampled bit.
module ovld_detect
    import ovld_pkg::*;
#(
    parameter int unsigned IDX_W    = 4,
    parameter int unsigned IFS_BITS = 2,
    parameter int unsigned EOF_LEN  = 7,
    parameter int unsigned DLM_LEN  = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sample_en,
    input  logic             bus_rx,
    input  logic [2:0]       field_sel,
    input  logic [IDX_W-1:0] bit_idx,
    input  logic             rx_mode,
    output logic             ovl_req,
    output logic [1:0]       ovl_cause
);
    logic [NUM_CAUSES-1:0] hit;
    logic                  any_hit;
    logic [1:0]            cause_nxt;
    logic                  fire;

    ovld_field_decode #(
        .IDX_W   (IDX_W),
        .IFS_BITS(IFS_BITS),
        .EOF_LEN (EOF_LEN),
        .DLM_LEN (DLM_LEN)
    ) decode_i (
        .field_sel(field_sel),
        .bit_idx  (bit_idx),
        .rx_mode  (rx_mode),
        .hit      (hit)
    );

    ovld_cause_enc enc_i (
        .hit    (hit),
        .any_hit(any_hit),
        .cause  (cause_nxt)
    );

    // Qualify the position hit with the strobe and a dominant level.
    always_comb fire = sample_en && !bus_rx && any_hit;

    // Register the request and the cause; the cause reads zero while idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ovl_req   <= 1'b0;
            ovl_cause <= 2'd0;
        end else begin
            ovl_req   <= fire;
            ovl_cause <= fire ? cause_nxt : 2'd0;
        end
    end

    // R7 R8: a request needs a strobed dominant sample one cycle earlier.
    a_r8_needs_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        !sample_en |=> !ovl_req);
    a_r7_recessive_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_en && bus_rx) |=> !ovl_req);
    // R4: dominant final end-of-frame bit while transmitting gives no request.
    a_r4_tx_eof_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_en && !bus_rx && field_sel == FLD_EOF && !rx_mode) |=> !ovl_req);
    // R2: third intermission bit is a start of frame.
    a_r2_ifs3_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (field_sel == FLD_IFS && bit_idx == IDX_W'(IFS_BITS)) |=> !ovl_req);
    // R5 R6: a dominant final delimiter bit gives the matching cause.
    a_r5_errdlm_cause: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_en && !bus_rx && field_sel == FLD_ERRDLM && bit_idx == IDX_W'(DLM_LEN-1))
        |=> (ovl_req && ovl_cause == CAUSE_ERRDLM));
    a_r6_ovldlm_cause: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_en && !bus_rx && field_sel == FLD_OVLDLM && bit_idx == IDX_W'(DLM_LEN-1))
        |=> (ovl_req && ovl_cause == CAUSE_OVLDLM));
    // R9: the cause reads zero while no request is raised.
    a_r9_idle_cause: assert property (@(posedge clk) disable iff (!rst_n)
        !ovl_req |-> ovl_cause == 2'd0);
    // R10: reset clears the request on the following cycle.
    a_r10_reset_clear: assert property (@(posedge clk)
        !rst_n |=> (!ovl_req && ovl_cause == 2'd0));

endmodule

// File: tb/ovld_detect_tb_top.sv
// Testbench for ovld_detect. A vector table is walked first, then directed
// tests cover reset, pulse width, back-to-back requests and mid-pulse reset.
module ovld_detect_tb_top;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       sample_en;
    logic       bus_rx;
    logic [2:0] field_sel;
    logic [3:0] bit_idx;
    logic       rx_mode;
    logic       ovl_req;
    logic [1:0] ovl_cause;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #4 clk = ~clk;  // 125 MHz

    ovld_detect dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .sample_en(sample_en),
        .bus_rx   (bus_rx),
        .field_sel(field_sel),
        .bit_idx  (bit_idx),
        .rx_mode  (rx_mode),
        .ovl_req  (ovl_req),
        .ovl_cause(ovl_cause)
    );

    // Vector: {en, bus, field, idx, rx, exp_req, exp_cause, req_no}
    localparam int NV = 17;
    localparam logic [16:0] VEC [NV] = '{
        {1'b1,1'b0,3'd2,4'd0,1'b1, 1'b1,2'd0, 4'd1},  // R1 ifs bit 0
        {1'b1,1'b0,3'd2,4'd1,1'b0, 1'b1,2'd0, 4'd1},  // R1 ifs bit 1
        {1'b1,1'b0,3'd2,4'd2,1'b1, 1'b0,2'd0, 4'd2},  // R2 ifs bit 2
        {1'b1,1'b0,3'd1,4'd6,1'b1, 1'b1,2'd1, 4'd3},  // R3 eof last rx
        {1'b1,1'b0,3'd1,4'd5,1'b1, 1'b0,2'd0, 4'd3},  // R3 eof bit 5
        {1'b1,1'b0,3'd1,4'd0,1'b1, 1'b0,2'd0, 4'd3},  // R3 eof bit 0
        {1'b1,1'b0,3'd1,4'd6,1'b0, 1'b0,2'd0, 4'd4},  // R4 eof last tx
        {1'b1,1'b0,3'd3,4'd7,1'b1, 1'b1,2'd2, 4'd5},  // R5 err delim last
        {1'b1,1'b0,3'd3,4'd6,1'b1, 1'b0,2'd0, 4'd5},  // R5 err delim bit 6
        {1'b1,1'b0,3'd4,4'd7,1'b0, 1'b1,2'd3, 4'd6},  // R6 ovl delim last
        {1'b1,1'b0,3'd4,4'd6,1'b0, 1'b0,2'd0, 4'd6},  // R6 ovl delim bit 6
        {1'b1,1'b1,3'd2,4'd0,1'b1, 1'b0,2'd0, 4'd7},  // R7 recessive ifs
        {1'b1,1'b1,3'd1,4'd6,1'b1, 1'b0,2'd0, 4'd7},  // R7 recessive eof
        {1'b1,1'b0,3'd0,4'd7,1'b1, 1'b0,2'd0, 4'd7},  // R7 field other
        {1'b1,1'b0,3'd5,4'd7,1'b1, 1'b0,2'd0, 4'd7},  // R7 unused code
        {1'b0,1'b0,3'd3,4'd7,1'b1, 1'b0,2'd0, 4'd8},  // R8 no strobe
        {1'b0,1'b0,3'd2,4'd0,1'b1, 1'b0,2'd0, 4'd8}   // R8 no strobe ifs
    };

    // Compare the outputs with the expected values and count the result.
    task automatic check(input string req, input logic er, input logic [1:0] ec);
        n_checks++;
        if (ovl_req !== er || ovl_cause !== ec) begin
            n_fail++;
            $display("FAIL %s: req=%b cause=%0d expected req=%b cause=%0d",
                     req, ovl_req, ovl_cause, er, ec);
        end
    endtask

    // Drive one strobe cycle at the falling edge.
    task automatic drive(input logic en, input logic b, input logic [2:0] f,
                         input logic [3:0] i, input logic rx);
        sample_en = en; bus_rx = b; field_sel = f; bit_idx = i; rx_mode = rx;
    endtask

    task automatic idle();
        drive(1'b0, 1'b1, 3'd0, 4'd0, 1'b1);
    endtask

    initial begin
        rst_n = 1'b0;
        drive(1'b1, 1'b0, 3'd3, 4'd7, 1'b1);  // would trigger if not in reset
        repeat (3) @(negedge clk);
        check("R10 reset state", 1'b0, 2'd0);
        rst_n = 1'b1;
        idle();
        @(negedge clk);

        // Table walk: one strobe, result seen at the next falling edge.
        for (int k = 0; k < NV; k++) begin
            drive(VEC[k][16], VEC[k][15], VEC[k][14:12], VEC[k][11:8], VEC[k][7]);
            @(negedge clk);
            check($sformatf("R%0d vector %0d", VEC[k][3:0], k), VEC[k][6], VEC[k][5:4]);
        end

        // R9: the request lasts one cycle and then falls back to idle.
        idle(); @(negedge clk);
        drive(1'b1, 1'b0, 3'd4, 4'd7, 1'b1);
        @(negedge clk);
        check("R9 pulse high", 1'b1, 2'd3);
        idle();
        @(negedge clk);
        check("R9 pulse ends", 1'b0, 2'd0);

        // R9: back-to-back strobes with different causes.
        drive(1'b1, 1'b0, 3'd2, 4'd0, 1'b1);
        @(negedge clk);
        check("R9 back-to-back first", 1'b1, 2'd0);
        drive(1'b1, 1'b0, 3'd2, 4'd1, 1'b1);
        @(negedge clk);
        check("R9 back-to-back second", 1'b1, 2'd0);
        drive(1'b1, 1'b0, 3'd3, 4'd7, 1'b0);
        @(negedge clk);
        check("R9 back-to-back third", 1'b1, 2'd2);
        idle();
        @(negedge clk);
        check("R9 after burst", 1'b0, 2'd0);

        // R10: reset while a request is pending clears it.
        drive(1'b1, 1'b0, 3'd1, 4'd6, 1'b1);
        @(negedge clk);
        check("R3 before reset", 1'b1, 2'd1);
        rst_n = 1'b0;
        @(negedge clk);
        check("R10 mid-pulse reset", 1'b0, 2'd0);
        rst_n = 1'b1;
        idle();
        @(negedge clk);
        check("R10 after release idle", 1'b0, 2'd0);

        done = 1'b1;
    end

    // Report when the run ends or when the watchdog expires.
    initial begin
        int cyc = 0;
        while (!done && cyc < 5000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: done=0 expected done=1");
        end
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule